// File: doc/BRIEF.md
# Control-Register Receiver for a Two-Wire Serial Bus

This block is a write-only I2C target that loads a bank of nine 8-bit function registers used to set up an audio-control datapath. It runs on a fast system clock and samples the bus lines through synchronisers. It finds START and STOP conditions and matches a fixed 7-bit device address. Every byte of an addressed transfer is acknowledged by pulling SDA low through an open-drain style low-enable output.

After the address byte, bit 7 of each byte gives its kind. A byte with bit 7 clear selects a function. A byte with bit 7 set is a value, and it is stored whole, bit 7 included, in the selected function register. Selections and values may be interleaved freely within one transfer. A selection stays in force until the next selection. When the increment flag is set in the selection byte, each value byte first advances the function index and is then stored, so the first value lands one function past the selected one.

The register contents leave the block as one flat parallel vector. The contents come up at defined power-on values. The system clock must run at least 8 times faster than SCL.

Top module: `ctl_i2c_regbank`

## Requirements
- R1: After reset, the registers hold these values: volume 0xFF, surround/effect 0xFF, bass 0x8F, treble 0x8F, rec-out right 0xFF, rec-out left 0xFF, right out 0xFF, left out 0xFF, input stage 0x80. Function k sits at `regs_o[8k+7:8k]`, where k is the index given in R4.
- R2: After a START, the block acknowledges the byte 0x82 (address 7'b1000001 with write bit 0). It does not acknowledge any other first byte.
- R3: In an addressed transfer, a byte with bit 7 = 0 selects a function. A byte with bit 7 = 1 is written whole to the selected function. The selection persists, so several values in a row all go to the same function and the last one wins.
- R4: The select field of a selection byte is bits [4:1]. Bits [6:5] are ignored. If field[2:0] is 0..6, it maps to index 0..6 (volume, surround/effect, bass, treble, rec-out right, rec-out left, right out) whatever field[3] holds. If field[2:0] = 7, field[3] = 0 selects left out (7) and field[3] = 1 selects input stage (8).
- R5: Bit 0 of a selection byte enables increment mode. In that mode each value byte first advances the index and is then stored. Index 8 wraps to 0.
- R6: A value byte that arrives in a transfer before any selection byte is acknowledged and discarded. Every START clears the selection.
- R7: After an address mismatch, SDA stays released and the bus is ignored until the next START. A repeated START restarts address matching.
- R8: Selections and values may be mixed in any order within one transfer, and each value follows the most recent selection.
- R9: SDA is pulled low only during the acknowledge clock. It is released at the SCL falling edge that ends that clock, and on STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_low_o | output | 1 | When high, the SDA pad is pulled low |
| regs_o | output | 72 | Function registers, function k at bits [8k+7:8k] |

## Verification
A bad function index or a stale selection shows up as a value in the wrong slice of `regs_o`. That error is visible a few system clocks after the acknowledge of the value byte, so the bench compares all nine slices after every transfer. A broken bit counter or address state shows up within the same byte, as a missing or misplaced acknowledge. Increment errors are exposed by the wrap from input stage back to volume. Selection state that survives a START is exposed by a value sent right after a repeated START.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;
  localparam int FUNC_W   = 8;
  localparam int NUM_FUNC = 9;
  localparam int IDX_W    = $clog2(NUM_FUNC);
  localparam int BITS_PER_BYTE = 8;

  typedef enum logic [1:0] {RX_IDLE, RX_BITS, RX_ACK} rx_state_e;

  function automatic logic [FUNC_W-1:0] func_reset(int k);
    case (k)
      2, 3:    return 8'h8F;
      8:       return 8'h80;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] sel_to_idx(logic [3:0] sel);
    if (sel[2:0] == 3'd7) return sel[3] ? IDX_W'(8) : IDX_W'(7);
    return IDX_W'(sel[2:0]);
  endfunction
endpackage

// File: rtl/ctl_i2c_sync.sv
module ctl_i2c_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    st_q[s] <= '1;
      else if (s == 0) st_q[s] <= d_i;
      else            st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ctl_i2c_byte_rx.sv
module ctl_i2c_byte_rx
  import ctl_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h41
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       start_o,
  output logic       byte_valid_o,
  output logic [7:0] byte_o,
  output logic       sda_low_o
);
  localparam int CNT_W = $clog2(BITS_PER_BYTE + 1);

  logic scl_q, sda_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_c  = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_c   = scl_i & scl_q & ~sda_q & sda_i;

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [7:0]        sh_q;
  logic              first_q, drive_q, valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      first_q <= 1'b0;
      drive_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (start_c) begin
        state_q <= RX_BITS;
        cnt_q   <= '0;
        first_q <= 1'b1;
        drive_q <= 1'b0;
      end else if (stop_c) begin
        state_q <= RX_IDLE;
        drive_q <= 1'b0;
      end else begin
        case (state_q)
          RX_BITS: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == CNT_W'(BITS_PER_BYTE)) begin
              if (first_q) begin
                if (sh_q == {DEV_ADDR, 1'b0}) begin
                  drive_q <= 1'b1;
                  state_q <= RX_ACK;
                end else begin
                  state_q <= RX_IDLE;
                end
              end else begin
                valid_q <= 1'b1;
                drive_q <= 1'b1;
                state_q <= RX_ACK;
              end
            end
          end
          RX_ACK: begin
            if (scl_fall) begin
              drive_q <= 1'b0;
              cnt_q   <= '0;
              first_q <= 1'b0;
              state_q <= RX_BITS;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign start_o      = start_c;
  assign byte_valid_o = valid_q;
  assign byte_o       = sh_q;
  assign sda_low_o    = drive_q;

  a_r9_drive_only_in_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_q |-> state_q == RX_ACK);
  a_r9_release_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_c |=> !drive_q);
  a_r9_drive_starts_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_q) |-> !scl_i);
  a_r7_idle_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_IDLE && !start_c) |=> !drive_q && !valid_q);
endmodule

// File: rtl/ctl_i2c_func_bank.sv
module ctl_i2c_func_bank
  import ctl_i2c_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic                       byte_valid_i,
  input  logic [7:0]                 byte_i,
  output logic [NUM_FUNC*FUNC_W-1:0] regs_o
);
  logic [IDX_W-1:0] idx_q, idx_next, tgt;
  logic             sel_ok_q, incr_q, is_value, wr_en;
  logic             unused_bits;

  assign unused_bits = ^byte_i[6:5];
  assign is_value = byte_i[7];
  assign idx_next = (idx_q == IDX_W'(NUM_FUNC - 1)) ? '0 : idx_q + 1'b1;
  assign tgt      = incr_q ? idx_next : idx_q;
  assign wr_en    = byte_valid_i & is_value & sel_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      sel_ok_q <= 1'b0;
      incr_q   <= 1'b0;
    end else if (start_i) begin
      sel_ok_q <= 1'b0;
      incr_q   <= 1'b0;
    end else if (byte_valid_i) begin
      if (!is_value) begin
        idx_q    <= sel_to_idx(byte_i[4:1]);
        incr_q   <= byte_i[0];
        sel_ok_q <= 1'b1;
      end else if (wr_en) begin
        idx_q <= tgt;
      end
    end
  end

  for (genvar k = 0; k < NUM_FUNC; k++) begin : g_func
    logic [FUNC_W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       r_q <= func_reset(k);
      else if (wr_en && tgt == IDX_W'(k)) r_q <= byte_i;
    end
    assign regs_o[k*FUNC_W +: FUNC_W] = r_q;
  end

  a_r5_idx_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q < IDX_W'(NUM_FUNC));
  a_r6_orphan_value_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && is_value && !sel_ok_q) |=> $stable(regs_o));
  a_r3_select_keeps_regs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && !is_value) |=> $stable(regs_o));
  a_r5_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && incr_q && idx_q == IDX_W'(NUM_FUNC - 1)) |=> idx_q == '0);
endmodule

// File: rtl/ctl_i2c_regbank.sv
module ctl_i2c_regbank
  import ctl_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h41,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_low_o,
  output logic [NUM_FUNC*FUNC_W-1:0] regs_o
);
  logic [1:0] bus_s;
  logic       start, byte_valid;
  logic [7:0] rx_byte;

  ctl_i2c_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (bus_s)
  );

  ctl_i2c_byte_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_i       (bus_s[1]),
    .sda_i       (bus_s[0]),
    .start_o     (start),
    .byte_valid_o(byte_valid),
    .byte_o      (rx_byte),
    .sda_low_o   (sda_low_o)
  );

  ctl_i2c_func_bank u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .byte_valid_i(byte_valid),
    .byte_i      (rx_byte),
    .regs_o      (regs_o)
  );

  a_r8_write_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(regs_o) |-> sda_low_o);
endmodule

// File: tb/ctl_i2c_regbank_tb_top.sv
module ctl_i2c_regbank_tb_top;
  localparam int Q = 16;
  localparam int NF = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_low;
  logic [NF*8-1:0] regs;
  wire  sda_line = sda_m & ~sda_low;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] exp_r [NF];

  always #2 clk = ~clk;

  ctl_i2c_regbank dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_low_o(sda_low),
    .regs_o   (regs)
  );

  task automatic wait_q(int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_regs(string req);
    for (int k = 0; k < NF; k++) chk(req, regs[k*8 +: 8], exp_r[k]);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q(2);
    chk("R9 released after stop", sda_low, 1'b0);
  endtask

  task automatic send_byte(logic [7:0] b, logic exp_ack, string req);
    logic ack;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_q();
      scl_m = 1'b1; wait_q();
      scl_m = 1'b0; wait_q();
    end
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; repeat (Q/2) @(negedge clk);
    ack = ~sda_line;
    repeat (Q/2) @(negedge clk);
    scl_m = 1'b0; wait_q();
    chk(req, ack, exp_ack);
    chk("R9 released after ack clock", sda_low, 1'b0);
  endtask

  function automatic logic [7:0] sel_byte(logic [3:0] sel, logic inc);
    return {3'b000, sel, inc};
  endfunction

  task automatic t_reset();
    exp_r = '{8'hFF, 8'hFF, 8'h8F, 8'h8F, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h80};
    chk_regs("R1 reset values");
    chk("R9 idle released", sda_low, 1'b0);
  endtask

  task automatic t_sticky();
    bus_start();
    send_byte(8'h82, 1'b1, "R2 address ack");
    send_byte(sel_byte(4'd2, 1'b0), 1'b1, "R3 select ack");
    send_byte(8'h85, 1'b1, "R3 value ack");
    send_byte(8'h83, 1'b1, "R3 value ack");
    bus_stop();
    exp_r[2] = 8'h83;
    chk_regs("R3 sticky selection last wins");
  endtask

  task automatic t_decode_mix();
    bus_start();
    send_byte(8'h82, 1'b1, "R2 address ack");
    send_byte(sel_byte(4'b0111, 1'b0), 1'b1, "R8 select");
    send_byte(8'h91, 1'b1, "R8 value");
    send_byte(sel_byte(4'b1111, 1'b0) | 8'h60, 1'b1, "R4 select bits 6:5 ignored");
    send_byte(8'h92, 1'b1, "R8 value");
    send_byte(sel_byte(4'b1110, 1'b0), 1'b1, "R4 select");
    send_byte(8'h93, 1'b1, "R8 value");
    bus_stop();
    exp_r[7] = 8'h91; exp_r[8] = 8'h92; exp_r[6] = 8'h93;
    chk_regs("R4 R8 decode and mixing");
  endtask

  task automatic t_incr();
    bus_start();
    send_byte(8'h82, 1'b1, "R2 address ack");
    send_byte(sel_byte(4'd6, 1'b1), 1'b1, "R5 select incr");
    send_byte(8'hA1, 1'b1, "R5 value");
    send_byte(8'hA2, 1'b1, "R5 value");
    send_byte(8'hA3, 1'b1, "R5 value");
    send_byte(8'hA4, 1'b1, "R5 value");
    bus_stop();
    exp_r[7] = 8'hA1; exp_r[8] = 8'hA2; exp_r[0] = 8'hA3; exp_r[1] = 8'hA4;
    chk_regs("R5 increment and wrap");
  endtask

  task automatic t_orphan();
    bus_start();
    send_byte(8'h82, 1'b1, "R2 address ack");
    send_byte(8'hC5, 1'b1, "R6 orphan value acked");
    bus_stop();
    chk_regs("R6 orphan value discarded");
    bus_start();
    send_byte(8'h82, 1'b1, "R2 address ack");
    send_byte(8'hC7, 1'b1, "R6 orphan after prior selection acked");
    send_byte(sel_byte(4'd5, 1'b0), 1'b1, "R6 select");
    send_byte(8'hC6, 1'b1, "R6 value");
    bus_stop();
    exp_r[5] = 8'hC6;
    chk_regs("R6 start clears selection");
  endtask

  task automatic t_bad_addr();
    bus_start();
    send_byte(8'h84, 1'b0, "R2 wrong address not acked");
    send_byte(sel_byte(4'd0, 1'b0), 1'b0, "R7 ignored byte");
    send_byte(8'hEE, 1'b0, "R7 ignored byte");
    bus_stop();
    chk_regs("R7 mismatch ignored");
    bus_start();
    send_byte(8'h83, 1'b0, "R2 read bit not acked");
    bus_stop();
  endtask

  task automatic t_restart();
    bus_start();
    send_byte(8'h82, 1'b1, "R2 address ack");
    send_byte(sel_byte(4'd3, 1'b0), 1'b1, "R7 select");
    bus_start();
    send_byte(8'h02, 1'b0, "R7 repeated start mismatch");
    send_byte(8'hDD, 1'b0, "R7 ignored after mismatch");
    bus_start();
    send_byte(8'h82, 1'b1, "R7 repeated start match");
    send_byte(8'hB7, 1'b1, "R6 orphan after restart");
    send_byte(sel_byte(4'd3, 1'b0), 1'b1, "R7 select");
    send_byte(8'hB8, 1'b1, "R7 value");
    bus_stop();
    exp_r[3] = 8'hB8;
    chk_regs("R7 repeated start");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_sticky();
    t_decode_mix();
    t_incr();
    t_orphan();
    t_bad_addr();
    t_restart();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule